// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits beside a page table walker and judges one memory access per cycle. For each access it takes the three-bit permission code of the page entry that was found, the entry's modified bit, the kind of access (write or read, instruction fetch or data, user or supervisor) and the virtual address. It answers, one cycle later, with a fault type code and the read/write/execute rights that may be cached for the page. When the access is refused it also pulses a trap request and records the event in a fault status register and a fault address register.

Accesses arrive on a valid strobe with no ready signal. The block never stalls and never applies back-pressure: every cycle in which `acc_valid` is high produces exactly one response, with `rsp_valid` high, on the next cycle. The translation enable, the no-fault mode bit and the status-read strobe are plain level controls. Software reads the status through the `fsr` port and pulses `fsr_rd` to consume it.

Top module: `mmu_perm_checker`

## Requirements
- R1: The access index is {write, fetch, supervisor}: bit 2 is `acc_write`, bit 1 is `acc_fetch`, bit 0 is the inverse of `acc_user`. The fault type for index i and permission code c is the c-th digit (digit 0 first) of this row list: i0 00002033, i1 00002000, i2 22000233, i3 22000200, i4 20202233, i5 20202020, i6 22202233, i7 22202220. Zero means allowed.
- R2: The rights mask `rsp_perm` is {read, write, execute} with read in bit 2 and execute in bit 0. For both privilege levels codes 0 to 4 give R, RW, RX, RWX and X. For supervisor, codes 5, 6, 7 give RW, RX, RWX; for user they give R, none, none.
- R3: When the entry's modified bit is low, the write bit of the granted mask is cleared whatever the code allows.
- R4: With `nofault_en` high, a refused user access is let through: `rsp_code` is 0, the mask is granted as in R2 and R3, no trap is raised, and neither status register changes. Supervisor accesses still fault.
- R5: With `mmu_en` low every access gets mask 111, code 0 and no trap, and the status registers do not change.
- R6: On a fault with the status register at zero, the status becomes (index << 5) | fault type | 2.
- R7: On a fault with the status register nonzero and not being read, the status is first set to 1 (overflow mark) and then has (index << 5) | fault type | 2 OR-ed in.
- R8: A fault loads the access's virtual address into `far`; non-faulting accesses leave it unchanged.
- R9: A cycle with `fsr_rd` high clears the status register at that clock edge; a fault in the same cycle is recorded as on an empty register, without the overflow mark.
- R10: A fault raises exactly one of `trap_ifetch` (fetch bit set) or `trap_data` (fetch bit clear) for one cycle, in the cycle its response is valid.
- R11: `rsp_valid` follows `acc_valid` by one cycle; on a fault `rsp_code` carries the fault type and `rsp_perm` is 000. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_en | input | 1 | Translation and checking enabled |
| nofault_en | input | 1 | Let refused user accesses through |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_user | input | 1 | Access is made in user mode |
| acc_perm | input | 3 | Permission code from the page entry |
| acc_modified | input | 1 | Modified bit of the page entry |
| acc_vaddr | input | VA_W | Virtual address of the access |
| fsr_rd | input | 1 | Status read strobe, clears the status |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_code | output | 2 | Fault type, zero when allowed |
| rsp_perm | output | 3 | Granted rights {R,W,X} |
| trap_ifetch | output | 1 | Instruction fault trap request |
| trap_data | output | 1 | Data fault trap request |
| fsr | output | FSR_W | Fault status register |
| far | output | VA_W | Fault address register |

## Verification
A wrong lookup entry shows at once on `rsp_code` or `rsp_perm` in the response cycle of the one access that uses it, so the bench sweeps every index against every code. A status register that is updated wrongly is invisible in that response's code but shows on `fsr` in the same response cycle, and a missed overflow or missed clear only becomes visible on the next fault, so the bench runs back-to-back faults with and without an intervening read. A stale or wrongly loaded fault address shows on `far` in the response cycle of the fault.

// File: rtl/mmuchk_pkg.sv
package mmuchk_pkg;

  typedef logic [2:0] pcode_t;    // permission code from the page entry
  typedef logic [2:0] acc_idx_t;  // {write, fetch, supervisor}
  typedef logic [1:0] ftype_t;    // fault type, 0 = allowed
  typedef logic [2:0] rights_t;   // {read, write, execute}

  localparam int RIGHT_R = 2;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 0;

  localparam rights_t RIGHTS_NONE = 3'b000;
  localparam rights_t RIGHTS_ALL  = 3'b111;

  localparam int IDX_SHIFT = 5;   // position of the access index in the status

endpackage

// File: rtl/mmuchk_fault_lut.sv
module mmuchk_fault_lut
  import mmuchk_pkg::*;
(
  input  acc_idx_t idx,
  input  pcode_t   code,
  output ftype_t   ftype
);

  // One 16-bit word per access index; permission code c selects bits 2c+1:2c.
  logic [15:0] row;

  always_comb begin
    unique case (idx)
      3'd0:    row = 16'hF200;
      3'd1:    row = 16'h0200;
      3'd2:    row = 16'hF80A;
      3'd3:    row = 16'h080A;
      3'd4:    row = 16'hFA22;
      3'd5:    row = 16'h2222;
      3'd6:    row = 16'hFA2A;
      default: row = 16'h2A2A;
    endcase
  end

  assign ftype = row[2*code +: 2];

endmodule

// File: rtl/mmuchk_perm_lut.sv
module mmuchk_perm_lut
  import mmuchk_pkg::*;
(
  input  logic    user,
  input  pcode_t  code,
  input  logic    modified,
  output rights_t rights
);

  rights_t base;

  always_comb begin
    unique case (code)
      3'd0:    base = 3'b100;
      3'd1:    base = 3'b110;
      3'd2:    base = 3'b101;
      3'd3:    base = 3'b111;
      3'd4:    base = 3'b001;
      3'd5:    base = user ? 3'b100 : 3'b110;
      3'd6:    base = user ? 3'b000 : 3'b101;
      default: base = user ? 3'b000 : 3'b111;
    endcase
  end

  // Write right is withheld until the page has been marked modified.
  always_comb begin
    rights = base;
    if (!modified) rights[RIGHT_W] = 1'b0;
  end

endmodule

// File: rtl/mmuchk_status.sv
module mmuchk_status
  import mmuchk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int FSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_clr,
  input  logic             fault_evt,
  input  acc_idx_t         idx,
  input  ftype_t           ftype,
  input  logic [VA_W-1:0]  vaddr,
  output logic [FSR_W-1:0] fsr_q,
  output logic [VA_W-1:0]  far_q
);

  localparam int PAD_W = FSR_W - IDX_SHIFT - 3;

  logic [FSR_W-1:0] kept;
  logic [FSR_W-1:0] entry;
  logic [FSR_W-1:0] fsr_d;

  assign kept  = rd_clr ? '0 : fsr_q;
  assign entry = {{PAD_W{1'b0}}, idx, {(IDX_SHIFT-2){1'b0}}, ftype} |
                 FSR_W'(2);

  always_comb begin
    fsr_d = kept;
    if (fault_evt) begin
      fsr_d = ((kept != '0) ? FSR_W'(1) : '0) | entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      fsr_q <= fsr_d;
      if (fault_evt) far_q <= vaddr;
    end
  end

endmodule

// File: rtl/mmu_perm_checker.sv
module mmu_perm_checker
  import mmuchk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int FSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mmu_en,
  input  logic             nofault_en,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_fetch,
  input  logic             acc_user,
  input  logic [2:0]       acc_perm,
  input  logic             acc_modified,
  input  logic [VA_W-1:0]  acc_vaddr,
  input  logic             fsr_rd,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic [2:0]       rsp_perm,
  output logic             trap_ifetch,
  output logic             trap_data,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far
);

  acc_idx_t idx;
  ftype_t   lut_ftype;
  rights_t  lut_rights;
  logic     refused;
  logic     waived;
  logic     fault_evt;
  ftype_t   code_d;
  rights_t  perm_d;

  assign idx = {acc_write, acc_fetch, ~acc_user};

  mmuchk_fault_lut u_fault_lut (
    .idx   (idx),
    .code  (acc_perm),
    .ftype (lut_ftype)
  );

  mmuchk_perm_lut u_perm_lut (
    .user     (acc_user),
    .code     (acc_perm),
    .modified (acc_modified),
    .rights   (lut_rights)
  );

  assign refused   = (lut_ftype != '0);
  assign waived    = nofault_en & acc_user;
  assign fault_evt = acc_valid & mmu_en & refused & ~waived;

  always_comb begin
    if (!mmu_en) begin
      code_d = '0;
      perm_d = RIGHTS_ALL;
    end else if (refused && !waived) begin
      code_d = lut_ftype;
      perm_d = RIGHTS_NONE;
    end else begin
      code_d = '0;
      perm_d = lut_rights;
    end
  end

  mmuchk_status #(
    .VA_W  (VA_W),
    .FSR_W (FSR_W)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_clr    (fsr_rd),
    .fault_evt (fault_evt),
    .idx       (idx),
    .ftype     (lut_ftype),
    .vaddr     (acc_vaddr),
    .fsr_q     (fsr),
    .far_q     (far)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_code    <= '0;
      rsp_perm    <= '0;
      trap_ifetch <= 1'b0;
      trap_data   <= 1'b0;
    end else begin
      rsp_valid   <= acc_valid;
      rsp_code    <= acc_valid ? code_d : '0;
      rsp_perm    <= acc_valid ? perm_d : '0;
      trap_ifetch <= fault_evt & acc_fetch;
      trap_data   <= fault_evt & ~acc_fetch;
    end
  end

endmodule

// File: rtl/mmu_perm_checker_sva.sv
module mmu_perm_checker_sva #(
  parameter int VA_W  = 32,
  parameter int FSR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mmu_en,
  input logic             nofault_en,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             acc_fetch,
  input logic             acc_user,
  input logic [2:0]       acc_perm,
  input logic             acc_modified,
  input logic [VA_W-1:0]  acc_vaddr,
  input logic             fsr_rd,
  input logic             rsp_valid,
  input logic [1:0]       rsp_code,
  input logic [2:0]       rsp_perm,
  input logic             trap_ifetch,
  input logic             trap_data,
  input logic [FSR_W-1:0] fsr,
  input logic [VA_W-1:0]  far
);

  logic faulted;
  assign faulted = rsp_valid && (rsp_code != 2'd0);

  p_trap_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ifetch, trap_data}));

  p_trap_needs_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ifetch || trap_data) |-> faulted);

  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  p_fault_no_rights_r11: assert property (@(posedge clk) disable iff (!rst_n)
    faulted |-> (rsp_perm == 3'b000));

  p_far_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    faulted |-> (far == $past(acc_vaddr)));

  p_far_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !faulted |-> $stable(far));

  p_fsr_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    faulted |-> fsr[1]);

  p_fsr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fsr_rd) && !faulted) |-> (fsr == '0));

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(mmu_en)) |-> (rsp_perm == 3'b111 && rsp_code == 2'd0));

endmodule

bind mmu_perm_checker mmu_perm_checker_sva #(.VA_W(VA_W), .FSR_W(FSR_W)) u_sva (.*);

// File: tb/sim_mmu_perm_checker.sv
module sim_mmu_perm_checker;

  localparam int VA_W  = 32;
  localparam int FSR_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mmu_en = 1'b0;
  logic             nofault_en = 1'b0;
  logic             acc_valid = 1'b0;
  logic             acc_write = 1'b0;
  logic             acc_fetch = 1'b0;
  logic             acc_user = 1'b0;
  logic [2:0]       acc_perm = '0;
  logic             acc_modified = 1'b0;
  logic [VA_W-1:0]  acc_vaddr = '0;
  logic             fsr_rd = 1'b0;
  logic             rsp_valid;
  logic [1:0]       rsp_code;
  logic [2:0]       rsp_perm;
  logic             trap_ifetch;
  logic             trap_data;
  logic [FSR_W-1:0] fsr;
  logic [VA_W-1:0]  far;

  always #10 clk = ~clk;  // 50 MHz

  mmu_perm_checker #(.VA_W(VA_W), .FSR_W(FSR_W)) u0 (.*);

  typedef struct {
    logic [1:0]       code;
    logic [2:0]       perm;
    logic             ti;
    logic             td;
    logic [FSR_W-1:0] fsr;
    logic [VA_W-1:0]  far;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  // Independent model tables (R1, R2).
  int ftab [8][8] = '{
    '{0,0,0,0,2,0,3,3}, '{0,0,0,0,2,0,0,0},
    '{2,2,0,0,0,2,3,3}, '{2,2,0,0,0,2,0,0},
    '{2,0,2,0,2,2,3,3}, '{2,0,2,0,2,0,2,0},
    '{2,2,2,0,2,2,3,3}, '{2,2,2,0,2,2,2,0}};
  int rtab_sup [8] = '{4, 6, 5, 7, 1, 6, 5, 7};
  int rtab_usr [8] = '{4, 6, 5, 7, 1, 4, 0, 0};

  logic [FSR_W-1:0] m_fsr = '0;
  logic [VA_W-1:0]  m_far = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic access(input bit en, input bit nf, input bit w, input bit f,
                        input bit u, input int pc, input bit md,
                        input logic [VA_W-1:0] va, input bit rd, input string req);
    exp_t e;
    int   idx;
    int   fc;
    bit   fault;
    logic [FSR_W-1:0] base;
    @(negedge clk);
    mmu_en = en; nofault_en = nf; acc_valid = 1'b1; acc_write = w;
    acc_fetch = f; acc_user = u; acc_perm = 3'(pc); acc_modified = md;
    acc_vaddr = va; fsr_rd = rd;
    idx = (w ? 4 : 0) + (f ? 2 : 0) + (u ? 0 : 1);
    fc = ftab[idx][pc];
    fault = en && (fc != 0) && !(nf && u);
    if (!en) begin
      e.code = 0; e.perm = 3'b111;
    end else if (fault) begin
      e.code = 2'(fc); e.perm = 3'b000;
    end else begin
      e.code = 0;
      e.perm = 3'(u ? rtab_usr[pc] : rtab_sup[pc]);
      if (!md) e.perm[1] = 1'b0;
    end
    base = rd ? '0 : m_fsr;
    if (fault) begin
      base = ((base != 0) ? FSR_W'(1) : FSR_W'(0)) | FSR_W'(idx * 32) |
             FSR_W'(fc) | FSR_W'(2);
      m_far = va;
    end
    m_fsr = base;
    e.ti = fault && f; e.td = fault && !f;
    e.fsr = m_fsr; e.far = m_far; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input bit rd);
    @(negedge clk);
    acc_valid = 1'b0; fsr_rd = rd;
    if (rd) m_fsr = '0;
  endtask

  // Monitor: compare each response against the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected rsp_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_code == e.code, e.req, "rsp_code", rsp_code, e.code);
        chk(rsp_perm == e.perm, e.req, "rsp_perm", rsp_perm, e.perm);
        chk(trap_ifetch == e.ti && trap_data == e.td, "R10", "traps",
            {trap_ifetch, trap_data}, {e.ti, e.td});
        chk(fsr == e.fsr, e.req, "fsr", fsr, e.fsr);
        chk(far == e.far, "R8", "far", far, e.far);
      end
    end else if (rst_n) begin
      chk(!trap_ifetch && !trap_data, "R10", "trap without response",
          {trap_ifetch, trap_data}, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(rsp_valid == 0 && rsp_code == 0 && rsp_perm == 0, "R11", "reset rsp",
        {rsp_valid, rsp_code, rsp_perm}, 0);
    chk(fsr == 0 && far == 0, "R11", "reset regs", {fsr, far}, 0);

    // R1 R2 R9: full sweep, reading the status every cycle
    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < 8; c++) begin
        access(1, 0, i[2], i[1], !i[0], c, 1, 32'h1000_0000 + i * 256 + c, 1, "R1");
      end
    end
    // R3: modified clear strips write from granted rights
    for (int c = 0; c < 8; c++) access(1, 0, 0, 0, 0, c, 0, 32'h2000_0000 + c, 1, "R3");
    for (int c = 0; c < 4; c++) access(1, 0, 0, 0, 1, c, 0, 32'h2100_0000 + c, 1, "R3");
    // R4: no-fault mode lets user faults through, supervisor still faults
    idle(1);
    access(1, 1, 0, 0, 1, 4, 1, 32'h3000_0004, 0, "R4");
    access(1, 1, 1, 0, 1, 6, 1, 32'h3000_0006, 0, "R4");
    access(1, 1, 1, 1, 0, 0, 1, 32'h3000_0100, 0, "R4");
    // R5: translation off grants everything
    idle(1);
    access(0, 0, 1, 1, 1, 6, 0, 32'h4000_0000, 0, "R5");
    access(0, 0, 0, 0, 1, 7, 1, 32'h4000_0010, 0, "R5");
    // R6 then R7: fresh fault, then overflow on a second unread fault
    access(1, 0, 0, 0, 1, 7, 1, 32'h5000_0000, 0, "R6");
    access(1, 0, 1, 0, 0, 0, 1, 32'h5000_0040, 0, "R7");
    access(1, 0, 0, 1, 1, 6, 1, 32'h5000_0080, 0, "R7");
    // R8: allowed access keeps the old fault address
    access(1, 0, 0, 0, 0, 3, 1, 32'h6000_0000, 0, "R8");
    // R9: read alone clears, next fault recorded fresh
    idle(1);
    idle(0);
    chk(fsr == 0, "R9", "fsr after read", fsr, 0);
    access(1, 0, 1, 1, 1, 5, 1, 32'h7000_0000, 0, "R9");
    // R10: back-to-back faults give one trap each
    access(1, 0, 0, 1, 1, 0, 1, 32'h8000_0000, 1, "R10");
    access(1, 0, 1, 0, 1, 0, 1, 32'h8000_0004, 1, "R10");
    idle(0);
    idle(0);
    idle(0);
    chk(exp_q.size() == 0, "R11", "responses outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule